// File: doc/BRIEF.md
# Dirty Line Refresh Coalescer

This block walks a frame from the top line to the bottom once per refresh and decides, line by line, whether that line has to be redrawn. A line qualifies when the whole frame is forced to redraw, when the hardware cursor's vertical band covers it, or when the external dirty tracker reports a write anywhere in the line's byte span. The block puts the span of the line being examined on a query port. The tracker answers combinationally in the same cycle.

Adjacent qualifying lines are merged into one full-width rectangle. A rectangle is described only by its first line and its line count. These rectangles leave on a valid/ready command port, and the scan waits whenever a command has not yet been taken. After the last command has been accepted, the block raises a one-cycle request to clear dirty state over the lowest-to-highest byte range that any redrawn line covered. The geometry and the full-update flag are captured when a frame starts. The cursor band is sampled live.

Top module: `dirty_line_coalescer`

## Requirements
- R1: A line is redrawn if and only if fullUpdate was high at frame start, or cursorOn is high and cursorTop <= line <= cursorBottom, or dirtyHit is high while that line is queried.
- R2: While qryValid is high for line y, qryStart = frameBase + y*linePitch and qryEnd = qryStart + frameWidth*B - 1. B is 1 for pixFmt 0, 2 for pixFmt 1 and 4 for pixFmt 2 or 3. The offset advances by linePitch for every line, whether or not the line is redrawn.
- R3: When a clean line y follows a run of redrawn lines that began at line s, one command with cmdStart = s and cmdCount = y - s is issued. Commands leave in ascending line order, and no command has a zero count.
- R4: A run still open after the last line of a frame of height H is issued as a final command with cmdCount = H - s.
- R5: While cmdValid is high and cmdReady is low, cmdStart and cmdCount hold steady and the scan does not advance to the next line.
- R6: After the last command of a frame has been accepted, clrValid pulses for exactly one cycle, with clrLo = the start address of the first redrawn line and clrHi = the end address of the last redrawn line. If no line was redrawn, there is no pulse.
- R7: frameStart is ignored while busy is high, so a second pulse in mid-frame changes neither the commands nor the clear range. busy falls in the cycle of the clear pulse, or of the last command acceptance when there is nothing to clear.
- R8: A frame of height 0 issues no command and no clear.
- R9: After reset, busy, qryValid, cmdValid and clrValid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Begin a refresh scan (when idle) |
| frameBase | input | ADDR_W | Byte address of line 0 |
| frameHeight | input | LINE_W | Lines per frame |
| frameWidth | input | WIDTH_W | Pixels per line (at least 1) |
| pixFmt | input | 2 | Pixel size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| linePitch | input | ADDR_W | Bytes between line starts |
| fullUpdate | input | 1 | Redraw every line of the frame |
| cursorOn | input | 1 | Cursor band active |
| cursorTop | input | LINE_W | First line covered by the cursor |
| cursorBottom | input | LINE_W | Last line covered by the cursor |
| qryValid | output | 1 | A line span is being queried |
| qryStart | output | ADDR_W | First byte of the queried span |
| qryEnd | output | ADDR_W | Last byte of the queried span |
| dirtyHit | input | 1 | Queried span holds dirty bytes |
| cmdValid | output | 1 | Update command offered |
| cmdReady | input | 1 | Consumer takes the command |
| cmdStart | output | LINE_W | First line of the rectangle |
| cmdCount | output | LINE_W | Lines in the rectangle |
| clrValid | output | 1 | One-cycle clear-dirty request |
| clrLo | output | ADDR_W | Lowest byte to clear |
| clrHi | output | ADDR_W | Highest byte to clear |
| busy | output | 1 | A frame scan is in progress |

## Verification
If the run-open flag or the recorded run start is corrupted, the first clean line after a run yields a command with the wrong start or count, or a command where none is expected. The scoreboard catches it at the handshake where that command is accepted. A wrong line offset shows up on the query port in the very cycle the line is examined, and also in the clear range at the end of the frame. A broken stall shows up within one cycle as a command that changes while it is still waiting, or as a query that moves on while the command waits. Ready patterns that are always high, alternating, and mostly low are used so that stalls land both on mid-frame commands and on the final flush.

// File: rtl/dlrc_pkg.sv
package dlrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FLUSH,
    ST_DRAIN
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic init;   // capture geometry, reset run and range
    logic scan;   // evaluate current line and advance
    logic flush;  // emit any run left open
    logic clear;  // raise the clear-dirty pulse
  } ctlStrobe_t;
endpackage

// File: rtl/dlrc_datapath.sv
module dlrc_datapath
  import dlrc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LINE_W  = 11,
  parameter int WIDTH_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [ADDR_W-1:0]  frameBase,
  input  logic [LINE_W-1:0]  frameHeight,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic [1:0]         pixFmt,
  input  logic [ADDR_W-1:0]  linePitch,
  input  logic               fullUpdate,
  input  logic               cursorOn,
  input  logic [LINE_W-1:0]  cursorTop,
  input  logic [LINE_W-1:0]  cursorBottom,
  input  logic               dirtyHit,
  input  logic               cmdReady,
  output logic [ADDR_W-1:0]  qryStart,
  output logic [ADDR_W-1:0]  qryEnd,
  output logic               cmdValid,
  output logic [LINE_W-1:0]  cmdStart,
  output logic [LINE_W-1:0]  cmdCount,
  output logic               clrValid,
  output logic [ADDR_W-1:0]  clrLo,
  output logic [ADDR_W-1:0]  clrHi,
  output logic               stall,
  output logic               lastLine,
  output logic               touched
);
  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  logic [LINE_W-1:0] lineIdx, runStart, hgt;
  logic [ADDR_W-1:0] lineOff, pitchR, spanR, spanEnd, loAddr, hiAddr;
  logic [ADDR_W-1:0] spanCalc;
  logic              fullR, runOpen, cursorHit, updNow;

  always_comb begin
    unique case (pixFmt)
      2'd0:    spanCalc = ADDR_W'(frameWidth);
      2'd1:    spanCalc = ADDR_W'(frameWidth) << 1;
      default: spanCalc = ADDR_W'(frameWidth) << 2;
    endcase
  end

  assign spanEnd   = lineOff + spanR - ONE_A;
  assign cursorHit = cursorOn && (lineIdx >= cursorTop) && (lineIdx <= cursorBottom);
  assign updNow    = fullR || cursorHit || dirtyHit;
  assign lastLine  = (lineIdx == hgt - ONE_L);
  assign stall     = cmdValid && !cmdReady;
  assign qryStart  = lineOff;
  assign qryEnd    = spanEnd;
  assign clrLo     = loAddr;
  assign clrHi     = hiAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineIdx  <= '0;
      runStart <= '0;
      hgt      <= '0;
      lineOff  <= '0;
      pitchR   <= '0;
      spanR    <= '0;
      loAddr   <= '1;
      hiAddr   <= '0;
      fullR    <= 1'b0;
      runOpen  <= 1'b0;
      touched  <= 1'b0;
      cmdValid <= 1'b0;
      cmdStart <= '0;
      cmdCount <= '0;
      clrValid <= 1'b0;
    end else begin
      clrValid <= strb.clear;
      if (cmdValid && cmdReady) cmdValid <= 1'b0;

      if (strb.init) begin
        lineIdx <= '0;
        lineOff <= frameBase;
        hgt     <= frameHeight;
        pitchR  <= linePitch;
        spanR   <= spanCalc;
        fullR   <= fullUpdate;
        runOpen <= 1'b0;
        loAddr  <= '1;
        hiAddr  <= '0;
        touched <= 1'b0;
      end

      if (strb.scan) begin
        lineIdx <= lineIdx + ONE_L;
        lineOff <= lineOff + pitchR;
        if (updNow) begin
          if (!runOpen) begin
            runOpen  <= 1'b1;
            runStart <= lineIdx;
          end
          touched <= 1'b1;
          if (lineOff < loAddr) loAddr <= lineOff;
          if (spanEnd > hiAddr) hiAddr <= spanEnd;
        end else if (runOpen) begin
          runOpen  <= 1'b0;
          cmdValid <= 1'b1;
          cmdStart <= runStart;
          cmdCount <= lineIdx - runStart;
        end
      end

      if (strb.flush && runOpen) begin
        runOpen  <= 1'b0;
        cmdValid <= 1'b1;
        cmdStart <= runStart;
        cmdCount <= hgt - runStart;
      end
    end
  end
endmodule

// File: rtl/dlrc_control.sv
module dlrc_control
  import dlrc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       heightZero,
  input  logic       stall,
  input  logic       lastLine,
  input  logic       cmdValid,
  input  logic       touched,
  output ctlStrobe_t strb,
  output logic       qryValid,
  output logic       busy
);
  scanState_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (frameStart) begin
        strb.init = 1'b1;
        nextState = heightZero ? ST_FLUSH : ST_SCAN;
      end
      ST_SCAN: if (!stall) begin
        strb.scan = 1'b1;
        if (lastLine) nextState = ST_FLUSH;
      end
      ST_FLUSH: if (!stall) begin
        strb.flush = 1'b1;
        nextState  = ST_DRAIN;
      end
      ST_DRAIN: if (!cmdValid) begin
        strb.clear = touched;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign qryValid = (state == ST_SCAN);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/dirty_line_coalescer.sv
module dirty_line_coalescer
  import dlrc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LINE_W  = 11,
  parameter int WIDTH_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic [ADDR_W-1:0]  frameBase,
  input  logic [LINE_W-1:0]  frameHeight,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic [1:0]         pixFmt,
  input  logic [ADDR_W-1:0]  linePitch,
  input  logic               fullUpdate,
  input  logic               cursorOn,
  input  logic [LINE_W-1:0]  cursorTop,
  input  logic [LINE_W-1:0]  cursorBottom,
  output logic               qryValid,
  output logic [ADDR_W-1:0]  qryStart,
  output logic [ADDR_W-1:0]  qryEnd,
  input  logic               dirtyHit,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [LINE_W-1:0]  cmdStart,
  output logic [LINE_W-1:0]  cmdCount,
  output logic               clrValid,
  output logic [ADDR_W-1:0]  clrLo,
  output logic [ADDR_W-1:0]  clrHi,
  output logic               busy
);
  ctlStrobe_t strb;
  logic stall, lastLine, touched;

  dlrc_control u_ctl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .heightZero(frameHeight == '0), .stall(stall), .lastLine(lastLine),
    .cmdValid(cmdValid), .touched(touched), .strb(strb),
    .qryValid(qryValid), .busy(busy)
  );

  dlrc_datapath #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WIDTH_W(WIDTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .frameBase(frameBase), .frameHeight(frameHeight), .frameWidth(frameWidth),
    .pixFmt(pixFmt), .linePitch(linePitch), .fullUpdate(fullUpdate),
    .cursorOn(cursorOn), .cursorTop(cursorTop), .cursorBottom(cursorBottom),
    .dirtyHit(dirtyHit), .cmdReady(cmdReady),
    .qryStart(qryStart), .qryEnd(qryEnd),
    .cmdValid(cmdValid), .cmdStart(cmdStart), .cmdCount(cmdCount),
    .clrValid(clrValid), .clrLo(clrLo), .clrHi(clrHi),
    .stall(stall), .lastLine(lastLine), .touched(touched)
  );
endmodule

// File: rtl/dlrc_checker.sv
module dlrc_checker #(
  parameter int ADDR_W = 24,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              qryValid,
  input logic [ADDR_W-1:0] qryStart,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [LINE_W-1:0] cmdStart,
  input logic [LINE_W-1:0] cmdCount,
  input logic              clrValid,
  input logic [ADDR_W-1:0] clrLo,
  input logic [ADDR_W-1:0] clrHi,
  input logic              busy
);
  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdStart) && $stable(cmdCount)));

  assert_scan_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (qryValid && cmdValid && !cmdReady) |=> (qryValid && $stable(qryStart)));

  assert_nonzero_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCount != '0));

  assert_clr_after_cmds_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrValid |-> (!cmdValid && !busy && (clrLo <= clrHi)));

  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrValid |=> !clrValid);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!qryValid && !cmdValid));
endmodule

bind dirty_line_coalescer dlrc_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .qryValid(qryValid), .qryStart(qryStart),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdStart(cmdStart),
  .cmdCount(cmdCount), .clrValid(clrValid), .clrLo(clrLo), .clrHi(clrHi),
  .busy(busy)
);

// File: tb/dirty_line_coalescer_tb.sv
module dirty_line_coalescer_tb;
  localparam int ADDR_W = 24, LINE_W = 11, WIDTH_W = 11;

  logic clk = 1'b0, rstN = 1'b0, frameStart = 1'b0;
  logic [ADDR_W-1:0] frameBase = '0, linePitch = '0;
  logic [LINE_W-1:0] frameHeight = '0, cursorTop = '0, cursorBottom = '0;
  logic [WIDTH_W-1:0] frameWidth = '0;
  logic [1:0] pixFmt = '0;
  logic fullUpdate = 1'b0, cursorOn = 1'b0, dirtyHit, cmdReady = 1'b0;
  logic qryValid, cmdValid, clrValid, busy;
  logic [ADDR_W-1:0] qryStart, qryEnd, clrLo, clrHi;
  logic [LINE_W-1:0] cmdStart, cmdCount;

  always #4 clk = ~clk;  // 125 MHz

  dirty_line_coalescer #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .WIDTH_W(WIDTH_W)) u_dut (.*);

  int checks = 0, fails = 0, cyc = 0, readyMode = 0, clrSeen = 0;
  int expStartQ[$], expCntQ[$];
  int tbBase = 0, tbPitch = 1, tbSpan = 1, tbHeight = 0;
  bit expClr = 0;
  int expLo = 0, expHi = 0;
  logic [63:0] dirtyTab = '0;
  bit prevStall = 0;
  int prevS = 0, prevC = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // dirty tracker model: answers for the queried line
  always_comb begin
    int ln;
    ln = (tbPitch != 0) ? (int'(qryStart) - tbBase) / tbPitch : 0;
    dirtyHit = qryValid && ln >= 0 && ln < 64 && dirtyTab[ln];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    case (readyMode)
      0: cmdReady = 1'b1;
      1: cmdReady = cyc[0];
      default: cmdReady = (cyc % 4 == 3);
    endcase
    if (rstN) begin
      if (prevStall) begin
        chk(cmdValid && int'(cmdStart) == prevS, "R5", "held start", cmdStart, prevS);
        chk(int'(cmdCount) == prevC, "R5", "held count", cmdCount, prevC);
      end
      prevStall = cmdValid && !cmdReady;
      prevS = cmdStart; prevC = cmdCount;
      if (qryValid) begin
        int rel;
        rel = int'(qryStart) - tbBase;
        chk(rel >= 0 && rel % tbPitch == 0 && rel / tbPitch < tbHeight, "R2",
            "query start on line grid", qryStart, tbBase);
        chk(int'(qryEnd) == int'(qryStart) + tbSpan - 1, "R2", "query end",
            qryEnd, int'(qryStart) + tbSpan - 1);
      end
      if (cmdValid && cmdReady) begin
        if (expStartQ.size() == 0) begin
          chk(0, "R3", "unexpected command start", cmdStart, -1);
        end else begin
          int es, ec;
          es = expStartQ.pop_front(); ec = expCntQ.pop_front();
          chk(int'(cmdStart) == es, "R3", "command start", cmdStart, es);
          chk(int'(cmdCount) == ec, "R4", "command count", cmdCount, ec);
        end
      end
      if (clrValid) begin
        clrSeen++;
        chk(expClr, "R6", "clear pulse allowed", 1, expClr);
        chk(int'(clrLo) == expLo, "R6", "clear low", clrLo, expLo);
        chk(int'(clrHi) == expHi, "R6", "clear high", clrHi, expHi);
      end
    end
  end

  task automatic runFrame(input int h, input int w, input int fmt, input int pitch,
                          input int base, input bit full, input bit cOn,
                          input int cTop, input int cBot, input logic [63:0] dmask,
                          input int rmode, input bit restart);
    int runS, nbytes, cnt;
    bit open;
    nbytes = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;
    tbBase = base; tbPitch = pitch; tbSpan = w * nbytes; tbHeight = h;
    dirtyTab = dmask; readyMode = rmode;
    expClr = 0; expLo = 0; expHi = 0; clrSeen = 0; open = 0; runS = 0;
    for (int y = 0; y < h; y++) begin
      bit upd;
      upd = full || (cOn && y >= cTop && y <= cBot) || dmask[y];  // R1
      if (upd) begin
        if (!open) begin open = 1; runS = y; end
        if (!expClr) expLo = base + y * pitch;
        expHi = base + y * pitch + tbSpan - 1;
        expClr = 1;
      end else if (open) begin
        expStartQ.push_back(runS); expCntQ.push_back(y - runS); open = 0;
      end
    end
    if (open) begin expStartQ.push_back(runS); expCntQ.push_back(h - runS); end
    @(negedge clk);
    frameHeight = LINE_W'(h); frameWidth = WIDTH_W'(w); pixFmt = 2'(fmt);
    linePitch = ADDR_W'(pitch); frameBase = ADDR_W'(base); fullUpdate = full;
    cursorOn = cOn; cursorTop = LINE_W'(cTop); cursorBottom = LINE_W'(cBot);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    chk(busy, "R7", "busy after start", busy, 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      frameHeight = LINE_W'(3); fullUpdate = 1'b1; frameBase = '0;
      frameStart = 1'b1;  // R7: must be ignored
      @(negedge clk);
      frameStart = 1'b0;
    end
    cnt = 0;
    while (busy && cnt < 5000) begin @(negedge clk); cnt++; end
    @(negedge clk);
    chk(expStartQ.size() == 0, "R3", "commands left over", expStartQ.size(), 0);
    chk(clrSeen == (expClr ? 1 : 0), "R6", "clear pulses", clrSeen, expClr ? 1 : 0);
    chk(!busy && !cmdValid, "R7", "idle after frame", busy, 0);
    expStartQ.delete(); expCntQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cmdValid && !clrValid && !qryValid, "R9", "reset outputs",
        {busy, cmdValid, clrValid, qryValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 R3 dirty lines 2..4 and 8, 2-byte pixels
    runFrame(12, 10, 1, 32, 'h100, 0, 0, 0, 0, 64'h11C, 0, 0);
    // R1 full update, R4 open run at end
    runFrame(5, 8, 0, 16, 'h40, 1, 0, 0, 0, 64'h0, 2, 0);
    // R1 cursor band 3..5 only, R5 alternating ready
    runFrame(9, 4, 2, 20, 0, 0, 1, 3, 5, 64'h0, 1, 0);
    // R6 nothing redrawn: no clear
    runFrame(7, 6, 0, 8, 'h10, 0, 0, 0, 0, 64'h0, 0, 0);
    // R4 first and last line only, R5 sparse ready
    runFrame(10, 3, 3, 12, 'h200, 0, 0, 0, 0, 64'h201, 2, 0);
    // R8 zero height
    runFrame(0, 3, 0, 12, 'h200, 1, 0, 0, 0, 64'h0, 0, 0);
    // R7 restart ignored mid-frame, cursor plus dirty merge into one run
    runFrame(20, 5, 1, 16, 'h300, 0, 1, 6, 7, 64'h2_0020, 1, 1);
    // R3 alternating dirty lines give unit runs, sparse ready
    runFrame(16, 2, 0, 4, 0, 0, 0, 0, 0, 64'h5555, 2, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule